// File: doc/BRIEF.md
# Floating-Point Load/Store-Multiple Address Sequencer

This block turns one load-multiple or store-multiple request into a stream of single-word memory requests. A one-cycle start pulse captures the request: its direction (load or store), an addressing mode, a register width class, a 32-bit base address, a writeback flag, the lowest register index and a register count. The block then presents one word request at a time. Each request carries a word-aligned byte address, the register index and a flag that selects the lower or upper half of a double-width register. A request stays on the outputs until the memory side accepts it with a ready input.

When the last word has been accepted, the block raises a one-cycle done strobe. With that strobe it presents the new base value and a writeback strobe, if the request asked for writeback. A request that breaks the encoding rules gets a one-cycle illegal pulse instead, and no word request is issued. The block computes only addresses, indices and handshake timing. Data movement, the register file and instruction decoding are handled by its neighbours.

Top module: `fpmx_seq`

## Requirements
- R1: After reset, and until a start is taken, `req_valid_o`, `busy_o`, `done_o`, `illegal_o` and `base_wr_o` are all low.
- R2: In an ascending transfer, the first word address is the base with bits [1:0] cleared. Each later word is 4 bytes higher. Mode codes are 0 = increment-after, 1 = decrement-before, 2 = empty-ascending stack, 3 = full-descending stack.
- R3: Mode 1 always descends. Mode 2 descends for loads and ascends for stores. Mode 3 ascends for loads and descends for stores. A descending transfer starts at aligned base minus 4 times the base delta, and it still issues words in ascending address order.
- R4: Width codes are 0 = single, 1 = double, 2 = unspecified, 3 = reserved. Single moves one word per register, with register index first+k and half flag 0. Double and unspecified move two words per register, with index first+k/2 and half flag k mod 2, lower half first.
- R5: Unspecified width moves exactly 2n words but has a base delta of 2n+1 words. In a descending mode, the first address is aligned base minus (2n+1)*4.
- R6: With done, `base_wr_o` equals the captured writeback flag. When the flag is set, `base_new_o` is aligned base plus or minus 4 times the delta (plus for ascending). When the flag is clear, `base_new_o` equals the base input unchanged.
- R7: A start taken while idle is illegal if any of these holds: the count is zero; the width code is 3; writeback is off and the mode is not 0; single width with first+count > 32; or another width with first+count > 16. An illegal start gives `illegal_o` high for exactly the next cycle, with no request and no done.
- R8: While `req_valid_o` is high and `req_ready_i` is low, the address, register index and half flag stay unchanged.
- R9: `done_o` is high for exactly one cycle, in the cycle after the last word is accepted, and `req_valid_o` is low then.
- R10: A start pulse while busy is ignored: the running sequence goes on unchanged and no illegal pulse follows.
- R11: Address arithmetic wraps modulo 2^32, both for the word addresses and for the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse; taken only while idle |
| is_load_i | input | 1 | 1 = load, 0 = store |
| mode_i | input | 2 | Addressing mode code |
| width_i | input | 2 | Register width code |
| base_i | input | 32 | Base byte address |
| wback_i | input | 1 | Write the updated base back |
| first_reg_i | input | 5 | Lowest register index of the range |
| reg_count_i | input | 6 | Number of registers in the range |
| req_valid_o | output | 1 | Word request present |
| req_ready_i | input | 1 | Memory side accepts the current word |
| req_addr_o | output | 32 | Word byte address |
| req_reg_o | output | 5 | Register index of the word |
| req_half_o | output | 1 | 0 = lower half, 1 = upper half |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle end-of-transfer strobe |
| illegal_o | output | 1 | One-cycle illegal-request pulse |
| base_wr_o | output | 1 | Base writeback strobe, with done |
| base_new_o | output | 32 | Base value offered with done |

## Verification
The sweep covers every direction, mode, width and writeback combination. It uses register ranges that touch the top of the single and double register files and bases next to address zero and the top of the address space. The stack modes are where a design is most likely to go wrong: one that swaps the direction table for loads and stores would emit addresses that go the wrong way from the base. Unspecified width in a descending mode is the other hard case. A design that reserves only 2n words there would start one word too high, and one that issues 2n+1 words would produce an extra request. Random-looking ready stalls and starts injected mid-transfer catch requests that move while stalled, done strobes one cycle off, and a busy block that re-arms or flags illegal on a stray start.

// File: rtl/fpmx_pkg.sv
// Shared codes for the load/store-multiple sequencer.
// Assumes mode and width arrive as 2-bit codes from the decoder.
package fpmx_pkg;

    typedef enum logic [1:0] {
        MODE_INC_AFTER  = 2'd0,
        MODE_DEC_BEFORE = 2'd1,
        MODE_STK_EMPTY  = 2'd2,
        MODE_STK_FULL   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        WID_SINGLE  = 2'd0,
        WID_DOUBLE  = 2'd1,
        WID_UNSPEC  = 2'd2,
        WID_RSVD    = 2'd3
    } width_e;

endpackage

// File: rtl/fpmx_cfg_check.sv
// Request decoder: resolves direction from mode and load/store, sizes
// the transfer in words and base-delta words, and checks legality.
// Assumes inputs are stable in the cycle they are evaluated.
module fpmx_cfg_check
    import fpmx_pkg::*;
#(
    parameter int NUM_SREG = 32,
    localparam int IDX_W   = $clog2(NUM_SREG),
    localparam int CNT_W   = IDX_W + 1,
    localparam int WRD_W   = CNT_W + 1
) (
    input  logic             is_load_i,
    input  logic [1:0]       mode_i,
    input  logic [1:0]       width_i,
    input  logic             wback_i,
    input  logic [IDX_W-1:0] first_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             legal_o,
    output logic             descend_o,
    output logic             two_per_reg_o,
    output logic [WRD_W-1:0] n_words_o,
    output logic [WRD_W-1:0] delta_words_o
);

    localparam int NUM_DREG = NUM_SREG / 2;
    localparam int SUM_W    = CNT_W + 1;

    mode_e            mode;
    width_e           width;
    logic [SUM_W-1:0] range_end;
    logic             range_bad;

    assign mode  = mode_e'(mode_i);
    assign width = width_e'(width_i);

    // Resolve the stack modes into a direction for this load/store.
    always_comb begin
        unique case (mode)
            MODE_INC_AFTER:  descend_o = 1'b0;
            MODE_DEC_BEFORE: descend_o = 1'b1;
            MODE_STK_EMPTY:  descend_o = is_load_i;
            MODE_STK_FULL:   descend_o = !is_load_i;
            default:         descend_o = 1'b0;
        endcase
    end

    // Word count and base delta for each width class.
    always_comb begin
        two_per_reg_o = (width != WID_SINGLE);
        if (two_per_reg_o) begin
            n_words_o = {count_i, 1'b0};
        end else begin
            n_words_o = WRD_W'(count_i);
        end
        if (width == WID_UNSPEC) begin
            delta_words_o = n_words_o + WRD_W'(1);
        end else begin
            delta_words_o = n_words_o;
        end
    end

    // Register range must fit inside the register file of its width.
    always_comb begin
        range_end = SUM_W'(first_i) + SUM_W'(count_i);
        if (two_per_reg_o) begin
            range_bad = range_end > SUM_W'(NUM_DREG);
        end else begin
            range_bad = range_end > SUM_W'(NUM_SREG);
        end
    end

    // Combine all legality rules.
    always_comb begin
        legal_o = 1'b1;
        if (count_i == '0)                        legal_o = 1'b0;
        if (width == WID_RSVD)                    legal_o = 1'b0;
        if (!wback_i && mode != MODE_INC_AFTER)   legal_o = 1'b0;
        if (range_bad)                            legal_o = 1'b0;
    end

endmodule

// File: rtl/fpmx_addr_plan.sv
// Address planner: from the base and the resolved direction it derives
// the lowest word address and the base value offered for writeback.
// Assumes delta is in words; all arithmetic wraps at ADDR_W bits.
module fpmx_addr_plan #(
    parameter int ADDR_W = 32,
    parameter int WRD_W  = 7
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic              descend_i,
    input  logic              wback_i,
    input  logic [WRD_W-1:0]  delta_words_i,
    output logic [ADDR_W-1:0] start_addr_o,
    output logic [ADDR_W-1:0] base_next_o
);

    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] low_end;
    logic [ADDR_W-1:0] updated;

    // Byte offset of the whole block and its two possible end points.
    always_comb begin
        aligned = base_i & ~ADDR_W'(3);
        offset  = ADDR_W'({delta_words_i, 2'b00});
        low_end = aligned - offset;
        updated = descend_i ? low_end : (aligned + offset);
    end

    // Lowest address is issued first; base passes through unless written back.
    always_comb begin
        start_addr_o = descend_i ? low_end : aligned;
        base_next_o  = wback_i ? updated : base_i;
    end

endmodule

// File: rtl/fpmx_walker.sv
// Word walker: issues one request per accepted word, ascending in address,
// advancing register index and half flag; pulses fin after the last word.
// Assumes load_i is only asserted while busy_o is low and n_words_i > 0.
module fpmx_walker #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 5,
    parameter int WRD_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [IDX_W-1:0]  first_i,
    input  logic              two_per_reg_i,
    input  logic [WRD_W-1:0]  n_words_i,
    input  logic              ready_i,
    output logic              busy_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [IDX_W-1:0]  reg_o,
    output logic              half_o,
    output logic              fin_o
);

    logic              busy_q;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  reg_q;
    logic              half_q;
    logic              pair_q;
    logic [WRD_W-1:0]  left_q;
    logic              fin_q;
    logic              take;

    assign take = busy_q && ready_i;

    // Busy flag and remaining word count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            left_q <= '0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (load_i) begin
                busy_q <= 1'b1;
                left_q <= n_words_i;
            end else if (take) begin
                left_q <= left_q - WRD_W'(1);
                if (left_q == WRD_W'(1)) begin
                    busy_q <= 1'b0;
                    fin_q  <= 1'b1;
                end
            end
        end
    end

    // Address, register index and half select for the current word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            reg_q  <= '0;
            half_q <= 1'b0;
            pair_q <= 1'b0;
        end else if (load_i) begin
            addr_q <= start_addr_i;
            reg_q  <= first_i;
            half_q <= 1'b0;
            pair_q <= two_per_reg_i;
        end else if (take) begin
            addr_q <= addr_q + ADDR_W'(4);
            if (!pair_q || half_q) begin
                reg_q  <= reg_q + IDX_W'(1);
                half_q <= 1'b0;
            end else begin
                half_q <= 1'b1;
            end
        end
    end

    assign busy_o = busy_q;
    assign addr_o = addr_q;
    assign reg_o  = reg_q;
    assign half_o = half_q;
    assign fin_o  = fin_q;

endmodule

// File: rtl/fpmx_seq.sv
// Top of the load/store-multiple sequencer. Takes a start only while
// idle, reports illegal requests for one cycle, runs the word walker for
// legal ones and offers the new base with the done strobe.
// Assumes start_i is a pulse; inputs other than start_i matter only with it.
module fpmx_seq
    import fpmx_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NUM_SREG = 32,
    localparam int IDX_W   = $clog2(NUM_SREG),
    localparam int CNT_W   = IDX_W + 1,
    localparam int WRD_W   = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              is_load_i,
    input  logic [1:0]        mode_i,
    input  logic [1:0]        width_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              wback_i,
    input  logic [IDX_W-1:0]  first_reg_i,
    input  logic [CNT_W-1:0]  reg_count_i,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [IDX_W-1:0]  req_reg_o,
    output logic              req_half_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              illegal_o,
    output logic              base_wr_o,
    output logic [ADDR_W-1:0] base_new_o
);

    logic              legal;
    logic              descend;
    logic              two_per_reg;
    logic [WRD_W-1:0]  n_words;
    logic [WRD_W-1:0]  delta_words;
    logic [ADDR_W-1:0] start_addr;
    logic [ADDR_W-1:0] base_next;
    logic              walk_busy;
    logic              walk_fin;
    logic              take_start;
    logic              go;
    logic              illegal_q;
    logic              wb_q;
    logic [ADDR_W-1:0] base_q;

    fpmx_cfg_check #(
        .NUM_SREG (NUM_SREG)
    ) u_check (
        .is_load_i     (is_load_i),
        .mode_i        (mode_i),
        .width_i       (width_i),
        .wback_i       (wback_i),
        .first_i       (first_reg_i),
        .count_i       (reg_count_i),
        .legal_o       (legal),
        .descend_o     (descend),
        .two_per_reg_o (two_per_reg),
        .n_words_o     (n_words),
        .delta_words_o (delta_words)
    );

    fpmx_addr_plan #(
        .ADDR_W (ADDR_W),
        .WRD_W  (WRD_W)
    ) u_plan (
        .base_i        (base_i),
        .descend_i     (descend),
        .wback_i       (wback_i),
        .delta_words_i (delta_words),
        .start_addr_o  (start_addr),
        .base_next_o   (base_next)
    );

    // Starts are honoured only while no transfer is running.
    assign take_start = start_i && !walk_busy;
    assign go         = take_start && legal;

    fpmx_walker #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .WRD_W  (WRD_W)
    ) u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_i        (go),
        .start_addr_i  (start_addr),
        .first_i       (first_reg_i),
        .two_per_reg_i (two_per_reg),
        .n_words_i     (n_words),
        .ready_i       (req_ready_i),
        .busy_o        (walk_busy),
        .addr_o        (req_addr_o),
        .reg_o         (req_reg_o),
        .half_o        (req_half_o),
        .fin_o         (walk_fin)
    );

    // One-cycle illegal pulse for a rejected start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= take_start && !legal;
        end
    end

    // Hold the writeback decision and base value for the done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_q   <= 1'b0;
            base_q <= '0;
        end else if (go) begin
            wb_q   <= wback_i;
            base_q <= base_next;
        end
    end

    assign req_valid_o = walk_busy;
    assign busy_o      = walk_busy;
    assign done_o      = walk_fin;
    assign illegal_o   = illegal_q;
    assign base_wr_o   = walk_fin && wb_q;
    assign base_new_o  = base_q;

endmodule

// File: rtl/fpmx_seq_chk.sv
// Protocol checker for fpmx_seq, attached through bind.
module fpmx_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              req_valid_o,
    input logic              req_ready_i,
    input logic [ADDR_W-1:0] req_addr_o,
    input logic [IDX_W-1:0]  req_reg_o,
    input logic              req_half_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              illegal_o,
    input logic              base_wr_o
);

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)
            && $stable(req_reg_o) && $stable(req_half_o))); // R8

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_ready_i) |=>
            (!req_valid_o || req_addr_o == $past(req_addr_o) + ADDR_W'(4))); // R2

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (req_addr_o[1:0] == 2'b00)); // R11

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_DONE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(req_valid_o && req_ready_i) && !req_valid_o)); // R9

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!req_valid_o && !done_o)); // R7

    AST_ILLEGAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |=> !illegal_o); // R7

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> !illegal_o); // R10

    AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr_o |-> done_o); // R6

    AST_BUSY_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == req_valid_o); // R1

endmodule

bind fpmx_seq fpmx_seq_chk #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
) u_fpmx_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_addr_o  (req_addr_o),
    .req_reg_o   (req_reg_o),
    .req_half_o  (req_half_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .illegal_o   (illegal_o),
    .base_wr_o   (base_wr_o)
);

// File: tb/fpmx_seq_tb_top.sv
// Sweep bench for fpmx_seq: every direction, mode, width and writeback
// setting over boundary register ranges and wrap-prone bases.
module fpmx_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        is_load_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic [1:0]  width_i = '0;
    logic [31:0] base_i = '0;
    logic        wback_i = 1'b0;
    logic [4:0]  first_reg_i = '0;
    logic [5:0]  reg_count_i = '0;
    logic        req_ready_i = 1'b0;
    logic        req_valid_o;
    logic [31:0] req_addr_o;
    logic [4:0]  req_reg_o;
    logic        req_half_o;
    logic        busy_o;
    logic        done_o;
    logic        illegal_o;
    logic        base_wr_o;
    logic [31:0] base_new_o;

    int n_checks = 0;
    int n_fails  = 0;
    int rcnt     = 0;

    always #10 clk = !clk;

    fpmx_seq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .is_load_i   (is_load_i),
        .mode_i      (mode_i),
        .width_i     (width_i),
        .base_i      (base_i),
        .wback_i     (wback_i),
        .first_reg_i (first_reg_i),
        .reg_count_i (reg_count_i),
        .req_valid_o (req_valid_o),
        .req_ready_i (req_ready_i),
        .req_addr_o  (req_addr_o),
        .req_reg_o   (req_reg_o),
        .req_half_o  (req_half_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .illegal_o   (illegal_o),
        .base_wr_o   (base_wr_o),
        .base_new_o  (base_new_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_txn(input bit ld, input int mode, input int wid, input bit wb,
                           input logic [31:0] base, input int first, input int cnt);
        int          words;
        int          delta;
        bit          dec;
        bit          bad;
        logic [31:0] ab;
        logic [31:0] st;
        logic [31:0] nb;
        logic [31:0] prev_addr;
        string       atag;
        int          k;
        int          guard;
        bit          rdy;
        bit          prev_stall;
        bit          injected;

        words = (wid == 0) ? cnt : 2 * cnt;
        delta = (wid == 2) ? words + 1 : words;
        dec   = (mode == 1) || (mode == 2 && ld) || (mode == 3 && !ld);
        bad   = (cnt == 0) || (wid == 3) || (!wb && mode != 0)
              || ((wid == 0) ? (first + cnt > 32) : (first + cnt > 16));
        ab    = base & 32'hFFFF_FFFC;
        st    = dec ? ab - 32'(delta * 4) : ab;
        nb    = dec ? ab - 32'(delta * 4) : ab + 32'(delta * 4);
        atag  = (wid == 2) ? "R5" : (dec ? "R3" : "R2");

        @(negedge clk);
        is_load_i   = ld;
        mode_i      = 2'(mode);
        width_i     = 2'(wid);
        wback_i     = wb;
        base_i      = base;
        first_reg_i = 5'(first);
        reg_count_i = 6'(cnt);
        start_i     = 1'b1;
        @(negedge clk);
        start_i = 1'b0;

        if (bad) begin
            chk("R7 illegal pulse", 32'(illegal_o), 32'd1);
            chk("R7 no request", 32'(req_valid_o), 32'd0);
            @(negedge clk);
            chk("R7 pulse ends", 32'(illegal_o), 32'd0);
            chk("R7 no done", 32'(done_o), 32'd0);
            return;
        end

        chk("R7 legal quiet", 32'(illegal_o), 32'd0);
        k = 0;
        guard = 0;
        prev_stall = 1'b0;
        prev_addr = '0;
        injected = 1'b0;
        while (k < words && guard < 400) begin
            guard++;
            chk("R9 valid while words remain", 32'(req_valid_o), 32'd1);
            if (prev_stall) chk("R8 held while stalled", req_addr_o, prev_addr);
            if ((st + 32'(4 * k)) < st || st > ab) begin
                chk("R11 wrapped address", req_addr_o, st + 32'(4 * k));
            end else begin
                chk(atag, req_addr_o, st + 32'(4 * k));
            end
            if (wid == 0) begin
                chk("R4 single index", 32'(req_reg_o), 32'((first + k) % 32));
                chk("R4 single half", 32'(req_half_o), 32'd0);
            end else begin
                chk("R4 pair index", 32'(req_reg_o), 32'(first + k / 2));
                chk("R4 pair half", 32'(req_half_o), 32'(k % 2));
            end
            rdy = (rcnt % 4) != 3;
            rcnt++;
            prev_stall = !rdy;
            prev_addr = req_addr_o;
            req_ready_i = rdy;
            if (k == 1 && !injected) begin
                injected    = 1'b1;
                is_load_i   = !ld;
                mode_i      = 2'd1;
                wback_i     = 1'b0;
                reg_count_i = 6'd0;
                start_i     = 1'b1;
            end
            @(negedge clk);
            start_i = 1'b0;
            req_ready_i = 1'b0;
            chk("R10 no illegal while busy", 32'(illegal_o), 32'd0);
            if (rdy) k++;
        end
        if (guard >= 400) chk("R9 transfer ran too long", 32'd1, 32'd0);

        chk("R9 done after last word", 32'(done_o), 32'd1);
        chk("R9 valid low at done", 32'(req_valid_o), 32'd0);
        chk("R6 writeback strobe", 32'(base_wr_o), 32'(wb));
        if (wb) begin
            if (wid == 2) chk("R5 base moved 2n+1", base_new_o, nb);
            else if ((dec && nb > ab) || (!dec && nb < ab)) chk("R11 base wraps", base_new_o, nb);
            else chk("R6 updated base", base_new_o, nb);
        end else begin
            chk("R6 base unchanged", base_new_o, base);
        end
        @(negedge clk);
        chk("R9 done one cycle", 32'(done_o), 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] bases [3];
        int          counts [5];
        int          firsts [4];
        int          bi;
        bases[0]  = 32'h1000_0003;
        bases[1]  = 32'h0000_0008;
        bases[2]  = 32'hFFFF_FFF0;
        counts[0] = 0;  counts[1] = 1;  counts[2] = 3;  counts[3] = 16; counts[4] = 17;
        firsts[0] = 0;  firsts[1] = 13; firsts[2] = 15; firsts[3] = 31;
        bi = 0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset valid", 32'(req_valid_o), 32'd0);
        chk("R1 reset busy", 32'(busy_o), 32'd0);
        chk("R1 reset done", 32'(done_o), 32'd0);
        chk("R1 reset illegal", 32'(illegal_o), 32'd0);
        chk("R1 reset writeback", 32'(base_wr_o), 32'd0);

        for (int ld = 0; ld < 2; ld++) begin
            for (int md = 0; md < 4; md++) begin
                for (int wd = 0; wd < 4; wd++) begin
                    for (int wb = 0; wb < 2; wb++) begin
                        for (int ci = 0; ci < 5; ci++) begin
                            for (int fi = 0; fi < 4; fi++) begin
                                run_txn(ld[0], md, wd, wb[0], bases[bi],
                                        firsts[fi], counts[ci]);
                                bi = (bi + 1) % 3;
                            end
                        end
                    end
                end
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule